// File: doc/BRIEF.md
# Consecutive-Cycle Overcurrent Monitor

This block watches the peak inductor current of one buck regulator, one switching cycle at a time. At every cycle strobe it takes a digitised peak-current sample and compares it against a programmable limit code. It also compares the sample against a higher threshold set at one and a quarter times that code. A sample at or above the limit cuts the power switch until the next cycle begins. Runs of consecutive cycles at or above the higher threshold feed two counters: a short run raises a sticky warning with an active-low interrupt, and a long run latches a shutdown of the regulator.

The counters saturate at their targets and return to zero on any cycle that stays under the higher threshold. The host clears the warning with a one-clock strobe. Lowering the regulator enable releases the shutdown latch and clears the run counters and the cut. Sensing and gate driving lie outside the block. With the default parameters the warning run is 2 cycles and the shutdown run is 8 cycles.

Top module: `ocp_monitor`

## Requirements
- R1: The high threshold is L + floor(L/4) for limit code L, computed one bit wider than the sample so it never wraps; with L = 255 at 8 bits the threshold is 318 and no sample reaches it. "At or above" means greater than or equal.
- R2: When `cyc_strobe` is high and the sample is at or above L, `sw_off` is high from the next clock until the clock after the next strobe. A strobe whose sample is below L drops `sw_off` from the next clock, unless a shutdown is latched.
- R3: After two consecutive strobes whose samples are at or above the high threshold, `oc_warn` is 1 and `irq_n` is 0 no later than two clocks after the second strobe.
- R4: After eight consecutive such strobes, `shutdown` is latched no later than two clocks after the eighth strobe. While it is latched, `sw_off` stays 1.
- R5: While `reg_en` is 0, the block clears `shutdown`, the run counts and the cycle cut, and it ignores strobes. The shutdown latch holds until that happens.
- R6: `oc_warn` stays set until `warn_clr` is pulsed. It sets again at once if the current run is still at or above two. `irq_n` is always the inverse of `oc_warn`.
- R7: A strobe whose sample is below the high threshold returns the run count to zero. The counts saturate at their targets and never wrap, so a long over-threshold run keeps `shutdown` set.
- R8: After reset, `sw_off`, `oc_warn` and `shutdown` are 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Regulator enable; low releases shutdown and clears runs |
| cyc_strobe | input | 1 | One-clock pulse at each switching cycle, sample valid |
| peak_smp | input | SMP_W | Peak current sample of the cycle |
| ilim_code | input | SMP_W | Programmed current limit, same units as the sample |
| warn_clr | input | 1 | Host clear strobe for the warning |
| sw_off | output | 1 | Request to keep the power switch off |
| oc_warn | output | 1 | Sticky overcurrent warning |
| irq_n | output | 1 | Active-low interrupt request |
| shutdown | output | 1 | Latched regulator shutdown |

## Verification
A wrong run count does not stay hidden. A count that misses a below-threshold reset or wraps past its target makes `oc_warn` or `shutdown` differ from the model within two clocks of the strobe where the two disagree. A wrong cut register shows on `sw_off` one clock after the strobe. The bench samples every output after each modelled switching cycle. Because of that, a corrupted latch or counter shows up by the end of that cycle's window.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int MAX_W = 16;

  // one and a quarter of the limit, one bit wider so it cannot wrap
  function automatic logic [MAX_W:0] thr_125(input logic [MAX_W-1:0] code);
    thr_125 = {1'b0, code} + {3'b000, code[MAX_W-1:2]};
  endfunction

  function automatic logic reaches(input logic [MAX_W:0] smp, input logic [MAX_W:0] thr);
    reaches = (smp >= thr);
  endfunction
endpackage

// File: rtl/ocp_thresh.sv
module ocp_thresh #(
  parameter int SMP_W = 8
) (
  input  logic [SMP_W-1:0] smp,
  input  logic [SMP_W-1:0] code,
  output logic             at_lim,
  output logic             at_hi
);
  import ocp_pkg::*;

  logic [MAX_W-1:0] smp_x, code_x;
  logic [MAX_W:0]   hi_thr;

  always_comb begin
    smp_x  = MAX_W'(smp);
    code_x = MAX_W'(code);
    hi_thr = thr_125(code_x);
    at_lim = reaches({1'b0, smp_x}, {1'b0, code_x});
    at_hi  = reaches({1'b0, smp_x}, hi_thr);
  end
endmodule

// File: rtl/occ_run_counter.sv
module occ_run_counter #(
  parameter int TARGET = 2,
  parameter int CW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          over,
  output logic [CW-1:0] cnt,
  output logic          hit
);
  localparam logic [CW-1:0] TOP = CW'(TARGET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (step) begin
      if (!over)       cnt <= '0;
      else if (cnt != TOP) cnt <= cnt + 1'b1;
    end
  end

  assign hit = (cnt == TOP);
endmodule

// File: rtl/ocp_monitor.sv
module ocp_monitor #(
  parameter int SMP_W    = 8,
  parameter int WARN_RUN = 2,
  parameter int SD_RUN   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_en,
  input  logic             cyc_strobe,
  input  logic [SMP_W-1:0] peak_smp,
  input  logic [SMP_W-1:0] ilim_code,
  input  logic             warn_clr,
  output logic             sw_off,
  output logic             oc_warn,
  output logic             irq_n,
  output logic             shutdown
);
  localparam int MAX_RUN = (SD_RUN > WARN_RUN) ? SD_RUN : WARN_RUN;
  localparam int CNT_W   = $clog2(MAX_RUN + 1);
  localparam int N_RUN   = 2;

  // named internal events for the checker
  logic             at_lim, at_hi;
  logic             run_step, run_clr;
  logic [CNT_W-1:0] run_cnt [N_RUN];
  logic [N_RUN-1:0] run_hit;
  logic             warn_hit, sd_hit;
  logic [CNT_W-1:0] sd_cnt;
  logic             sw_cut;

  ocp_thresh #(.SMP_W(SMP_W)) u_thr (
    .smp(peak_smp), .code(ilim_code), .at_lim(at_lim), .at_hi(at_hi)
  );

  assign run_step = cyc_strobe & reg_en;
  assign run_clr  = ~reg_en;

  for (genvar g = 0; g < N_RUN; g++) begin : g_run
    localparam int TGT = (g == 0) ? WARN_RUN : SD_RUN;
    occ_run_counter #(.TARGET(TGT), .CW(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(run_clr), .step(run_step),
      .over(at_hi), .cnt(run_cnt[g]), .hit(run_hit[g])
    );
  end

  assign warn_hit = run_hit[0];
  assign sd_hit   = run_hit[1];
  assign sd_cnt   = run_cnt[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sw_cut <= 1'b0;
    else if (!reg_en)    sw_cut <= 1'b0;
    else if (cyc_strobe) sw_cut <= at_lim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shutdown <= 1'b0;
    else if (!reg_en) shutdown <= 1'b0;
    else if (sd_hit)  shutdown <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        oc_warn <= 1'b0;
    else if (warn_hit) oc_warn <= 1'b1;
    else if (warn_clr) oc_warn <= 1'b0;
  end

  assign sw_off = sw_cut | shutdown;
  assign irq_n  = ~oc_warn;
endmodule

// File: rtl/ocp_monitor_chk.sv
module ocp_monitor_chk #(
  parameter int SD_RUN = 8,
  parameter int CW     = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_en,
  input logic          cyc_strobe,
  input logic          warn_clr,
  input logic          at_hi,
  input logic          warn_hit,
  input logic [CW-1:0] sd_cnt,
  input logic          sw_cut,
  input logic          shutdown,
  input logic          oc_warn,
  input logic          irq_n
);
  p_cut_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !cyc_strobe) |=> $stable(sw_cut));

  p_irq_on_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    warn_hit |=> !irq_n);

  p_sd_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && reg_en) |=> shutdown);

  p_off_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en |=> (sd_cnt == '0 && !shutdown && !sw_cut));

  p_warn_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_warn && !warn_clr) |=> oc_warn);

  p_run_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_strobe && reg_en && !at_hi) |=> (sd_cnt == '0));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cnt <= CW'(SD_RUN));
endmodule

bind ocp_monitor ocp_monitor_chk #(.SD_RUN(SD_RUN), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .cyc_strobe(cyc_strobe),
  .warn_clr(warn_clr), .at_hi(at_hi), .warn_hit(warn_hit), .sd_cnt(sd_cnt),
  .sw_cut(sw_cut), .shutdown(shutdown), .oc_warn(oc_warn), .irq_n(irq_n)
);

// File: tb/tb_ocp_monitor.sv
module tb_ocp_monitor;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0, reg_en = 1'b0, cyc_strobe = 1'b0, warn_clr = 1'b0;
  logic [W-1:0] peak_smp = '0, ilim_code = '0;
  logic sw_off, oc_warn, irq_n, shutdown;

  int total = 0, bad = 0;
  int m_run = 0, m_lim = 0;
  bit m_cut = 0, m_warn = 0, m_sd = 0, done = 0;

  always #2 clk = ~clk;

  ocp_monitor #(.SMP_W(W), .WARN_RUN(2), .SD_RUN(8)) dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .cyc_strobe(cyc_strobe),
    .peak_smp(peak_smp), .ilim_code(ilim_code), .warn_clr(warn_clr),
    .sw_off(sw_off), .oc_warn(oc_warn), .irq_n(irq_n), .shutdown(shutdown)
  );

  function automatic int hi_of(input int lim);
    return lim + lim / 4;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b (lim=%0d run=%0d)", tag, act, exp, m_lim, m_run);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " sw_off"}, sw_off, m_cut | m_sd);
    chk({tag, " warn"}, oc_warn, m_warn);
    chk({tag, " irq_n R6"}, irq_n, ~m_warn);
    chk({tag, " shutdown"}, shutdown, m_sd);
  endtask

  task automatic do_cycle(input int smp, input string tag);
    @(negedge clk);
    peak_smp = W'(smp); ilim_code = W'(m_lim); cyc_strobe = 1'b1;
    @(negedge clk);
    cyc_strobe = 1'b0;
    repeat (2) @(negedge clk);
    if (reg_en) begin
      m_cut = (smp >= m_lim);
      m_run = (smp >= hi_of(m_lim)) ? ((m_run < 8) ? m_run + 1 : 8) : 0;
      if (m_run >= 2) m_warn = 1;
      if (m_run >= 8) m_sd = 1;
    end
    check_all(tag);
  endtask

  task automatic do_clear();
    @(negedge clk); warn_clr = 1'b1;
    @(negedge clk); warn_clr = 1'b0;
    @(negedge clk);
    m_warn = (m_run >= 2);
    check_all("R6 clear");
  endtask

  task automatic do_disable();
    @(negedge clk); reg_en = 1'b0;
    @(negedge clk); reg_en = 1'b1;
    @(negedge clk);
    m_run = 0; m_cut = 0; m_sd = 0;
    check_all("R5 disable");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h0C0FFEE5));
    repeat (3) @(negedge clk);
    check_all("R8 reset");
    rst_n = 1'b1; reg_en = 1'b1;
    @(negedge clk);
    check_all("R8 after reset");

    // R1 / R2 boundaries with L = 100, high threshold 125
    m_lim = 100;
    do_cycle(99, "R2 below limit");
    do_cycle(100, "R2 at limit");
    do_cycle(124, "R1 just below high");
    do_cycle(50, "R2 cut released");
    do_cycle(125, "R1 at high, run 1");
    do_cycle(125, "R3 run 2 warns");
    do_cycle(10, "R7 run broken");
    do_clear();
    do_cycle(200, "R7 run restart 1");
    chk("R7 no warn after restart", oc_warn, 1'b0);
    for (int i = 0; i < 9; i++) do_cycle(255, "R4 long run");
    chk("R4 shutdown latched", shutdown, 1'b1);
    do_cycle(0, "R4 sw_off held under shutdown");
    for (int i = 0; i < 4; i++) do_cycle(255, "R7 saturated run");
    do_clear();
    chk("R6 warn re-raised during run", oc_warn, 1'b1);
    do_disable();

    // R5 strobes ignored while disabled
    @(negedge clk); reg_en = 1'b0;
    do_cycle(255, "R5 strobe ignored");
    do_cycle(255, "R5 strobe ignored 2");
    @(negedge clk); reg_en = 1'b1;
    do_clear();
    do_cycle(255, "R5 run restarts at 1");
    chk("R5 no warn from ignored strobes", oc_warn, 1'b0);

    // R1 overflow corner: L = 255 -> high threshold 318
    m_lim = 255;
    for (int i = 0; i < 3; i++) do_cycle(255, "R1 wide threshold");
    chk("R1 no warn at max limit", oc_warn, 1'b0);
    // L = 0: everything reaches both thresholds
    m_lim = 0;
    do_cycle(0, "R1 zero limit 1");
    do_cycle(0, "R3 zero limit 2");
    do_disable();
    do_clear();

    // constrained random
    for (int n = 0; n < 600; n++) begin
      int pick, s, hi;
      if (n % 40 == 0) m_lim = $urandom_range(0, 220);
      hi = hi_of(m_lim);
      pick = $urandom_range(0, 9);
      if (pick < 6 && hi <= 255) s = $urandom_range(hi, 255);
      else if (pick < 8 && m_lim > 0) s = $urandom_range(0, m_lim - 1);
      else s = $urandom_range(m_lim, (hi > 255) ? 255 : hi);
      do_cycle(s, "rand R2/R3/R4/R7");
      if ($urandom_range(0, 29) == 0) do_clear();
      if ($urandom_range(0, 49) == 0) do_disable();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule